// File: doc/BRIEF.md
# Write-only two-wire clock configuration slave

This block is the control port of a clock generator. It listens on a two-wire serial bus (clock line and data line), both sampled by a fast local clock. It answers a single fixed write address and loads the bytes it receives into six 8-bit configuration registers. The register contents drive parallel outputs: one enable per generated clock, a software frequency-select field, the bit that selects the frequency-select source, and the operating-mode field.

A transfer is built as follows. First a start condition and the address byte. Then a command byte and a count byte; both are acknowledged and then discarded. The data bytes follow and always fill the registers from register 0 upward. The registers cannot be read back and have no sub-address, so changing one register means resending every register before it. Registers keep their values between transfers. Only the synchronous reset loads their defaults.

The slave acknowledges a byte by asserting `sda_pull`, which the pad logic turns into a low level on the data line. The slave never stretches the bus clock.

Top module: `clkcfg_wslave`

## Requirements
- R1: After reset the registers hold reg0=0xF4 and 0xFF in reg1 through reg5. At the ports this gives fsel_sw=3'b111, fsel_src=0, op_mode=2'b00, all enables 1, and sda_pull=0.
- R2: Only the address byte 0xD2 (7-bit address 0x69 with the write bit 0 in the LSB) is acknowledged. Any other first byte gets no acknowledge, and the transfer changes no register. This includes 0xD3, the read of the same address.
- R3: sda_pull is asserted only during the acknowledge bit that follows an accepted byte. It rises after the bus clock has fallen at the end of bit 8, and it drops after the next fall. It stays 0 during every data bit.
- R4: The two bytes after the address (command, then count) are acknowledged whatever their value, and they are never stored.
- R5: Data bytes are shifted in MSB first. The n-th data byte (n from 0) is written to register n, for n from 0 to 5.
- R6: After the address, at most 10 bytes are acknowledged, counting the command and count bytes. Data bytes 6 and 7 are acknowledged but stored nowhere. The 11th byte and any later byte are not acknowledged.
- R7: A transfer changes only the registers it reaches. All other registers keep their earlier values.
- R8: A start or a stop in the middle of a byte abandons that byte without storing it. A start at any point begins a new address match, so a repeated start followed by 0xD2 is acknowledged again.
- R9: Field map. reg0: bits 6:4 = fsel_sw, bit 3 = fsel_src, bits 1:0 = op_mode (11 tri-state, 10 spread-on, 01 test, 00 spread-off). reg1: bit 7 = usb48_en, bit 6 = usb24_en, bits 3:0 = cpu_en. reg2: bit 6 = pcif_en, bits 5:0 = pci_en. reg3: bits 7:0 = sdram_en[7:0]. reg4: bits 3:0 = sdram_en[11:8]. reg5: bit 4 = apic_en, bits 1:0 = ref_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset, loads register defaults |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = drive the data line low (acknowledge) |
| fsel_sw | output | 3 | Software frequency-select value |
| fsel_src | output | 1 | 0 = hardware straps, 1 = fsel_sw |
| op_mode | output | 2 | Operating mode code |
| cpu_en | output | 4 | Processor clock enables |
| usb48_en | output | 1 | 48 MHz clock enable |
| usb24_en | output | 1 | 24 MHz clock enable |
| pci_en | output | 6 | Stoppable bus clock enables |
| pcif_en | output | 1 | Free-running bus clock enable |
| sdram_en | output | 12 | Memory clock enables |
| apic_en | output | 1 | Interrupt-controller clock enable |
| ref_en | output | 2 | Reference clock enables |

## Verification
Two decisions land on the same bus-clock rising edge: the register write for a completed data byte, and the byte-limit check that chooses between acknowledge and no acknowledge. To provoke this, a transfer sends ten acknowledged bytes after the address and then an eleventh byte. The bench judges the result from the acknowledge bit it samples for each byte and from the output fields. The tenth byte must be acknowledged and stored nowhere. The eleventh must see the data line left high. The first six data bytes must be unchanged in the outputs afterwards.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int NUM_REGS = 6;
  localparam int REG_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK_DRV,
    ST_SKIP
  } slv_state_t;

  // power-up value of each register; reserved bits come up as 1
  function automatic logic [REG_W-1:0] reg_default(input int idx);
    if (idx == 0) return 8'hF4;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic lvl,
  output logic lvl_q
);

  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], line_in};
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl   = pipe[STAGES-1];
  assign lvl_q = prev;

endmodule

// File: rtl/byte_engine.sv
module byte_engine
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE  = 8'hD2,
  parameter int         MAX_ACK    = 10,
  parameter int         SKIP_BYTES = 2,
  parameter int         NREG       = 6,
  localparam int        IDXW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_s,
  input  logic            start_det,
  input  logic            stop_det,
  output logic            sda_pull,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data
);

  localparam int CNTW = $clog2(MAX_ACK + 2);
  localparam logic [CNTW-1:0] FIRST_DATA = CNTW'(SKIP_BYTES + 1);
  localparam logic [CNTW-1:0] LAST_ACK   = CNTW'(MAX_ACK);
  localparam logic [CNTW-1:0] REG_CNT    = CNTW'(NREG);

  slv_state_t      state;
  logic [2:0]      bit_cnt;
  logic [6:0]      sh;
  logic [CNTW-1:0] byte_num;   // 0 = address byte

  logic [7:0]      new_byte;
  logic [CNTW-1:0] slot;
  logic            byte_ok;
  logic            store_ok;

  always_comb begin
    new_byte = {sh, sda_s};
    slot     = byte_num - FIRST_DATA;
    store_ok = (byte_num >= FIRST_DATA) && (slot < REG_CNT);
    if (byte_num == '0) byte_ok = (new_byte == ADDR_BYTE);
    else                byte_ok = (byte_num <= LAST_ACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      byte_num <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        byte_num <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              sh      <= new_byte[6:0];
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (byte_ok) begin
                  state <= ST_ACK_WAIT;
                  if (store_ok) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= slot[IDXW-1:0];
                    wr_data <= new_byte;
                  end
                end else begin
                  state <= ST_SKIP;
                end
              end
            end
          end
          ST_ACK_WAIT: begin
            if (scl_fall) begin
              sda_pull <= 1'b1;
              state    <= ST_ACK_DRV;
            end
          end
          ST_ACK_DRV: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_RX;
              bit_cnt  <= '0;
              byte_num <= byte_num + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import clkcfg_pkg::*;
#(
  parameter int  NREG = 6,
  parameter int  DW   = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [NREG*DW-1:0] cfg_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)
        r <= DW'(reg_default(g));
      else if (wr_en && (wr_idx == IDXW'(g)))
        r <= wr_data;
    end
    assign cfg_flat[g*DW +: DW] = r;
  end

endmodule

// File: rtl/clkcfg_wslave.sv
module clkcfg_wslave
  import clkcfg_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR    = 8'hD2,
  parameter int         MAX_ACK     = 10,
  parameter int         SKIP_BYTES  = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_pull,
  output logic [2:0]  fsel_sw,
  output logic        fsel_src,
  output logic [1:0]  op_mode,
  output logic [3:0]  cpu_en,
  output logic        usb48_en,
  output logic        usb24_en,
  output logic [5:0]  pci_en,
  output logic        pcif_en,
  output logic [11:0] sdram_en,
  output logic        apic_en,
  output logic [1:0]  ref_en
);

  localparam int NREG = NUM_REGS;
  localparam int IDXW = $clog2(NREG);

  logic scl_s, scl_q, sda_s, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      wr_data;
  logic [NREG*REG_W-1:0] cfg_flat;

  line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_in(scl_in), .lvl(scl_s), .lvl_q(scl_q)
  );

  line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_in(sda_in), .lvl(sda_s), .lvl_q(sda_q)
  );

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  byte_engine #(
    .ADDR_BYTE(DEV_ADDR), .MAX_ACK(MAX_ACK),
    .SKIP_BYTES(SKIP_BYTES), .NREG(NREG)
  ) u_engine (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_bank #(.NREG(NREG), .DW(REG_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cfg_flat(cfg_flat)
  );

  // field map (R9)
  assign fsel_sw  = cfg_flat[6:4];
  assign fsel_src = cfg_flat[3];
  assign op_mode  = cfg_flat[1:0];
  assign usb48_en = cfg_flat[15];
  assign usb24_en = cfg_flat[14];
  assign cpu_en   = cfg_flat[11:8];
  assign pcif_en  = cfg_flat[22];
  assign pci_en   = cfg_flat[21:16];
  assign sdram_en = {cfg_flat[35:32], cfg_flat[31:24]};
  assign apic_en  = cfg_flat[44];
  assign ref_en   = cfg_flat[41:40];

endmodule

// File: rtl/clkcfg_wslave_chk.sv
module clkcfg_wslave_chk #(
  parameter int  NREG = 6,
  localparam int IDXW = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              stop_det,
  input logic              sda_pull,
  input logic              wr_en,
  input logic [IDXW-1:0]   wr_idx,
  input logic [NREG*8-1:0] cfg_flat
);

  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    rst |=> (cfg_flat[7:0] == 8'hF4) && (&cfg_flat[NREG*8-1:8]) && !sda_pull);

  // R3
  pull_on_low_clock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);

  // R8
  stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);

  // R5
  write_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx <= IDXW'(NREG - 1)));

  // R7
  hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_flat));

endmodule

bind clkcfg_wslave clkcfg_wslave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
  .sda_pull(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .cfg_flat(cfg_flat)
);

// File: tb/clkcfg_wslave_bench.sv
module clkcfg_wslave_bench;

  localparam int Q = 8;   // sampling-clock cycles per quarter bus bit

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_in, sda_pull;
  logic [2:0]  fsel_sw;
  logic        fsel_src;
  logic [1:0]  op_mode;
  logic [3:0]  cpu_en;
  logic        usb48_en, usb24_en, pcif_en, apic_en;
  logic [5:0]  pci_en;
  logic [11:0] sdram_en;
  logic [1:0]  ref_en;

  int total = 0;
  int bad = 0;
  int stray_pull = 0;
  bit done = 0;
  logic [7:0] exp_reg [0:5];
  logic [7:0] dbuf [0:11];

  always #4 clk = ~clk;

  assign sda_in = m_sda & ~sda_pull;

  clkcfg_wslave u_clkcfg_wslave (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_in), .sda_pull(sda_pull),
    .fsel_sw(fsel_sw), .fsel_src(fsel_src), .op_mode(op_mode),
    .cpu_en(cpu_en), .usb48_en(usb48_en), .usb24_en(usb24_en),
    .pci_en(pci_en), .pcif_en(pcif_en), .sdram_en(sdram_en),
    .apic_en(apic_en), .ref_en(ref_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every output field against the model registers (R9 map)
  task automatic check_all(input string tag);
    logic [33:0] act, exp;
    @(negedge clk);
    act = {fsel_sw, fsel_src, op_mode, usb48_en, usb24_en, cpu_en,
           pcif_en, pci_en, sdram_en, apic_en, ref_en};
    exp = {exp_reg[0][6:4], exp_reg[0][3], exp_reg[0][1:0],
           exp_reg[1][7], exp_reg[1][6], exp_reg[1][3:0],
           exp_reg[2][6], exp_reg[2][5:0],
           exp_reg[4][3:0], exp_reg[3],
           exp_reg[5][4], exp_reg[5][1:0]};
    chk(tag, 64'(act), 64'(exp));
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait(); qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; qwait(); m_scl = 1'b1; qwait();
      if (sda_pull) stray_pull++;
      qwait(); m_scl = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    ack = (sda_in == 1'b0);
    qwait(); m_scl = 1'b0; qwait();
  endtask

  // address, command, count, then n data bytes from dbuf; acks checked
  task automatic write_xfer(input int n, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a);   chk({tag, " R2 address ack"}, 64'(a), 64'd1);
    send_byte(8'hA7, a);   chk({tag, " R4 command ack"}, 64'(a), 64'd1);
    send_byte(8'h3C, a);   chk({tag, " R4 count ack"}, 64'(a), 64'd1);
    for (int j = 0; j < n; j++) begin
      logic e;
      e = ((j + 3) <= 10);
      send_byte(dbuf[j], a);
      chk({tag, " R6 data ack"}, 64'(a), 64'(e));
      if (e && j < 6) exp_reg[j] = dbuf[j];
    end
    bus_stop();
  endtask

  task automatic t_reset();
    exp_reg[0] = 8'hF4;
    for (int i = 1; i < 6; i++) exp_reg[i] = 8'hFF;
    check_all("R1 defaults");
    chk("R1 sda_pull idle", 64'(sda_pull), 64'd0);
  endtask

  task automatic t_full_write();
    dbuf[0] = 8'h3B; dbuf[1] = 8'h25; dbuf[2] = 8'h55;
    dbuf[3] = 8'hA5; dbuf[4] = 8'h0C; dbuf[5] = 8'h12;
    write_xfer(6, "full");
    check_all("R5 R9 six registers loaded in order");
    chk("R3 released after stop", 64'(sda_pull), 64'd0);
  endtask

  task automatic t_bad_address();
    logic a;
    bus_start();
    send_byte(8'hA4, a); chk("R2 foreign address nack", 64'(a), 64'd0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h00, a);
    chk("R2 no ack after foreign address", 64'(a), 64'd0);
    bus_stop();
    bus_start();
    send_byte(8'hD3, a); chk("R2 read nack", 64'(a), 64'd0);
    bus_stop();
    check_all("R2 registers untouched");
  endtask

  task automatic t_partial();
    dbuf[0] = 8'h81;
    write_xfer(1, "partial");
    check_all("R7 only reg0 changed");
  endtask

  task automatic t_limit();
    for (int j = 0; j < 9; j++) dbuf[j] = 8'(8'h60 + 8'(j * 9));
    write_xfer(9, "limit");
    check_all("R6 extra bytes not stored");
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_bits(8'h00, 4);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); qwait();
    bus_stop();
    check_all("R8 stop mid-byte stores nothing");
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h11, a); send_byte(8'h22, a);
    send_bits(8'hFF, 5);
    m_sda = 1'b1; qwait();
    bus_start();
    send_byte(8'hD2, a); chk("R8 address ack after repeated start", 64'(a), 64'd1);
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h40, a); chk("R8 data ack after restart", 64'(a), 64'd1);
    exp_reg[0] = 8'h40;
    bus_stop();
    check_all("R8 restart writes reg0");
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    m_sda = 1'b1; qwait();
    bus_start();
    send_byte(8'hD3, a); chk("R8 R2 read after repeated start nack", 64'(a), 64'd0);
    bus_stop();
    check_all("R8 registers held");
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_write();
    t_bad_address();
    t_partial();
    t_limit();
    t_abort();
    chk("R3 no pull during data bits", 64'(stray_pull), 64'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule